// File: doc/BRIEF.md
# SPI Master Engine with Select-Fault Detection

This block is the controlling end of an SPI link. It generates the serial clock from the system clock, shifts a word out on MOSI, and shifts a word in from MISO. Each word is written into a single transmit holding register and moved into the shifter when the engine starts the word. A one-cycle completion pulse marks the cycle in which the received word is placed in a read register. The engine runs only when the enable bit is set, the I2C-select bit is clear and the master bit is set. The divider, clock polarity, clock phase and handshake-enable settings are captured while the engine is not in master operation, and they are frozen while it is.

Two inputs guard the link. The first is a request line driven by the attached slave, which is active low. When the handshake is turned on, a word starts only while the slave asserts this line, so the slave paces the master one word at a time. The second is the engine's own slave-select input, which must stay high. If it is pulled low during master operation, the engine aborts any word in flight and parks the clock at its idle level. It also raises a sticky bus-error flag that blocks further words until software clears it. Both inputs pass through a two-flop synchronizer before they are used. Slave chip selects are produced outside this block.

Top module: `spi_host_engine`

## Requirements
- R1: Words start only while cfg_enable=1, cfg_i2c_sel=0 and cfg_master=1. In any other combination a written word stays pending (tx_full_o=1) and sck_o does not toggle.
- R2: cfg_div, cfg_cpol, cfg_cpha and cfg_hs_en are captured only while master operation is off. Changing them while it is on has no effect on timing, on the idle level or on gating.
- R3: With divider value N, each SCK half period is N+1 system clocks, and a word of WORD_W bits uses 2·WORD_W·(N+1) clocks. When tx_wr is held for one cycle with the engine idle and no handshake, done_o is seen 2·WORD_W·(N+1)+2 rising edges after tx_wr is first sampled, counting that edge as 1.
- R4: Data goes MSB first on both lines. The idle level of SCK equals cpol. With cpha=0, MOSI is valid before the first edge, both sides sample on leading edges and data changes on trailing edges. With cpha=1, data changes on leading edges and is sampled on trailing edges.
- R5: done_o is high for exactly one cycle per word. rx_word_o takes the received word in that same cycle and holds it until the next completion.
- R6: tx_wr loads tx_word only when tx_full_o=0 and is ignored when tx_full_o=1. tx_full_o clears when the word moves to the shifter.
- R7: With handshake enabled, a word starts only while hreq_n_i is low (after synchronization). While hreq_n_i stays high, the word stays pending.
- R8: ss_n_i low during master operation sets err_o on the third rising edge after it is applied (two synchronizer stages plus the flag). ss_n_i low while master operation is off does not set err_o.
- R9: err_o is sticky. err_clr clears it only when the select fault is absent, and the fault wins over err_clr.
- R10: A select fault aborts the current word: SCK returns to its idle level, no done_o follows for that word, and no new word starts while err_o=1.
- R11: After reset, sck_o=0, mosi_o=0, tx_full_o=0, done_o=0, err_o=0 and rx_word_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Block enable |
| cfg_i2c_sel | input | 1 | Selects I2C; must be 0 for SPI master operation |
| cfg_master | input | 1 | Selects master operation |
| cfg_div | input | 8 | Divider value N; SCK period is 2·(N+1) clocks |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_cpha | input | 1 | Clock phase |
| cfg_hs_en | input | 1 | Enables pacing of word starts by hreq_n_i |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_word | input | WORD_W | Word to transmit |
| tx_full_o | output | 1 | Transmit holding register occupied |
| rx_word_o | output | WORD_W | Last received word |
| done_o | output | 1 | One-cycle word completion pulse |
| err_o | output | 1 | Sticky bus-error flag |
| err_clr | input | 1 | Clears the bus-error flag |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ss_n_i | input | 1 | Own slave-select input, must stay high |
| hreq_n_i | input | 1 | Slave request input, active low |

## Verification
A corrupted bit counter or divider count shows at the ports as done_o arriving on the wrong edge. It can also show as SCK resting at the wrong level after the word, and the directed tests count edges to catch either within one word. A bad shifter or phase decode gives a wrong word both at rx_word_o and in the bench's slave model, which is checked at the completion pulse. A select-fault path that fails shows within three cycles of ss_n_i falling: err_o does not rise, SCK keeps toggling, or a late done_o appears. A stuck or lost pending flag shows as a word that never starts, or as a second write that overwrites the first.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

    localparam int DIV_W = 8;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } xfer_state_e;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             cpol;
        logic             cpha;
        logic             hs_en;
    } spi_cfg_t;

    // Edge index parity: even indices are leading edges, odd are trailing.
    function automatic logic edge_samples(input logic cpha, input logic odd_edge);
        return cpha ? odd_edge : ~odd_edge;
    endfunction

    function automatic logic edge_shifts(input logic cpha, input logic odd_edge,
                                         input logic first_edge, input logic last_edge);
        if (cpha)
            return ~odd_edge & ~first_edge;
        else
            return odd_edge & ~last_edge;
    endfunction

endpackage

// File: rtl/spi_host_sync.sv
module spi_host_sync #(
    parameter int              WIDTH   = 2,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= RST_VAL;
                else     chain[g] <= d;
            end
        end else begin : g_tail
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= RST_VAL;
                else     chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_host_clkgen.sv
module spi_host_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)     cnt <= '0;
        else if (cnt == div) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt == div);

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        run && $past(run) |-> cnt <= div);
endmodule

// File: rtl/spi_host_shifter.sv
module spi_host_shifter
    import spi_host_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              abort,
    input  logic              tick,
    input  logic              cpha,
    input  logic              miso,
    output logic              mosi,
    output logic              sck_lvl,
    output logic              fin,
    output logic [WORD_W-1:0] rx_word
);
    localparam int EDGES  = 2 * WORD_W;
    localparam int EDGE_W = $clog2(EDGES);
    localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(EDGES - 1);

    logic [WORD_W-1:0] tx_sh, rx_sh;
    logic [EDGE_W-1:0] ecnt;
    logic              lvl;
    logic              first_e, last_e, sample_now, shift_now;

    assign first_e    = (ecnt == '0);
    assign last_e     = (ecnt == LAST_EDGE);
    assign sample_now = tick && edge_samples(cpha, ecnt[0]);
    assign shift_now  = tick && edge_shifts(cpha, ecnt[0], first_e, last_e);
    assign rx_word    = sample_now ? {rx_sh[WORD_W-2:0], miso} : rx_sh;
    assign fin        = tick && last_e;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sh <= '0;
            rx_sh <= '0;
            ecnt  <= '0;
            lvl   <= 1'b0;
        end else if (load) begin
            tx_sh <= load_word;
            rx_sh <= '0;
            ecnt  <= '0;
            lvl   <= 1'b0;
        end else if (abort) begin
            ecnt  <= '0;
            lvl   <= 1'b0;
        end else if (tick) begin
            lvl   <= ~lvl;
            ecnt  <= last_e ? '0 : ecnt + 1'b1;
            rx_sh <= rx_word;
            if (shift_now) tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
        end
    end

    assign mosi    = tx_sh[WORD_W-1];
    assign sck_lvl = lvl;

    // R4
    sck_home_chk: assert property (@(posedge clk) disable iff (rst)
        fin |=> !lvl);
endmodule

// File: rtl/spi_host_engine.sv
module spi_host_engine
    import spi_host_pkg::*;
#(
    parameter int WORD_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_enable,
    input  logic              cfg_i2c_sel,
    input  logic              cfg_master,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic              cfg_hs_en,
    input  logic              tx_wr,
    input  logic [WORD_W-1:0] tx_word,
    output logic              tx_full_o,
    output logic [WORD_W-1:0] rx_word_o,
    output logic              done_o,
    output logic              err_o,
    input  logic              err_clr,
    output logic              sck_o,
    output logic              mosi_o,
    input  logic              miso_i,
    input  logic              ss_n_i,
    input  logic              hreq_n_i
);
    spi_cfg_t          cfg_q;
    xfer_state_e       st;
    logic              mode_on, ss_s, hreq_s, err_set, err_q;
    logic              tx_full_q, start, abort, run, tick, fin, sck_lvl;
    logic [WORD_W-1:0] tx_reg, rx_q, rx_next;
    logic              done_q;

    assign mode_on = cfg_enable & ~cfg_i2c_sel & cfg_master;

    // Settings shadow: follows inputs only while master operation is off
    always_ff @(posedge clk) begin
        if (rst)          cfg_q <= '0;
        else if (!mode_on) cfg_q <= '{div: cfg_div, cpol: cfg_cpol,
                                       cpha: cfg_cpha, hs_en: cfg_hs_en};
    end

    spi_host_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ss_n_i, hreq_n_i}),
        .q   ({ss_s, hreq_s})
    );

    assign err_set = mode_on & ~ss_s;

    always_ff @(posedge clk) begin
        if (rst)          err_q <= 1'b0;
        else if (err_set) err_q <= 1'b1;
        else if (err_clr) err_q <= 1'b0;
    end

    assign start = (st == ST_IDLE) && mode_on && !err_q && !err_set && tx_full_q
                   && (!cfg_q.hs_en || !hreq_s);
    assign abort = (st == ST_RUN) && (err_set || !mode_on);
    assign run   = (st == ST_RUN) && !abort;

    // Transmit holding register
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_full_q <= 1'b0;
            tx_reg    <= '0;
        end else if (start) begin
            tx_full_q <= 1'b0;
        end else if (tx_wr && !tx_full_q) begin
            tx_full_q <= 1'b1;
            tx_reg    <= tx_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                st <= ST_IDLE;
        else if (start)         st <= ST_RUN;
        else if (abort || fin)  st <= ST_IDLE;
    end

    spi_host_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .div  (cfg_q.div),
        .tick (tick)
    );

    spi_host_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (start),
        .load_word (tx_reg),
        .abort     (abort),
        .tick      (tick),
        .cpha      (cfg_q.cpha),
        .miso      (miso_i),
        .mosi      (mosi_o),
        .sck_lvl   (sck_lvl),
        .fin       (fin),
        .rx_word   (rx_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            rx_q   <= '0;
        end else begin
            done_q <= fin;
            if (fin) rx_q <= rx_next;
        end
    end

    assign sck_o     = cfg_q.cpol ^ sck_lvl;
    assign tx_full_o = tx_full_q;
    assign rx_word_o = rx_q;
    assign done_o    = done_q;
    assign err_o     = err_q;

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R10
    err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        err_q |-> (st == ST_IDLE) && (sck_o == cfg_q.cpol));

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err_q && !err_clr |=> err_q);

    // R2
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mode_on |=> $stable(cfg_q));

    // R6
    tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        tx_full_q && !start |=> tx_full_q && $stable(tx_reg));
endmodule

// File: tb/tb_spi_host_engine.sv
`timescale 1ns/1ps
module tb_spi_host_engine;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_enable = 1'b0, cfg_i2c_sel = 1'b0, cfg_master = 1'b1;
    logic [7:0] cfg_div = 8'd0;
    logic cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_hs_en = 1'b0;
    logic tx_wr = 1'b0;
    logic [W-1:0] tx_word = '0;
    logic tx_full_o, done_o, err_o, sck_o, mosi_o, miso_i;
    logic [W-1:0] rx_word_o;
    logic err_clr = 1'b0, ss_n_i = 1'b1, hreq_n_i = 1'b1;

    int checks = 0, fails = 0, done_cnt = 0, sck_tog = 0;

    always #2.5 clk = ~clk;

    spi_host_engine #(.WORD_W(W)) dut (
        .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_i2c_sel(cfg_i2c_sel),
        .cfg_master(cfg_master), .cfg_div(cfg_div), .cfg_cpol(cfg_cpol),
        .cfg_cpha(cfg_cpha), .cfg_hs_en(cfg_hs_en), .tx_wr(tx_wr), .tx_word(tx_word),
        .tx_full_o(tx_full_o), .rx_word_o(rx_word_o), .done_o(done_o), .err_o(err_o),
        .err_clr(err_clr), .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(miso_i),
        .ss_n_i(ss_n_i), .hreq_n_i(hreq_n_i)
    );

    // Behavioural slave
    logic [W-1:0] s_tx = '0, s_rx = '0;
    int  s_lead = 0;
    logic tb_cpol = 1'b0, tb_cpha = 1'b0;
    assign miso_i = s_tx[W-1];

    always @(posedge sck_o or negedge sck_o) begin
        sck_tog++;
        if (sck_o !== tb_cpol) begin
            if (!tb_cpha) s_rx = {s_rx[W-2:0], mosi_o};
            else begin
                if (s_lead > 0) s_tx = s_tx << 1;
                s_lead++;
            end
        end else begin
            if (!tb_cpha) s_tx = s_tx << 1;
            else          s_rx = {s_rx[W-2:0], mosi_o};
        end
    end

    always @(posedge clk) if (done_o === 1'b1) done_cnt++;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic slave_arm(input logic [W-1:0] sw);
        s_tx = sw; s_rx = '0; s_lead = 0;
    endtask

    task automatic setup(input logic [7:0] n, input logic pol, input logic pha, input logic hs);
        @(negedge clk);
        cfg_enable = 1'b0;
        cfg_div = n; cfg_cpol = pol; cfg_cpha = pha; cfg_hs_en = hs;
        tb_cpol = pol; tb_cpha = pha;
        @(negedge clk);
        cfg_enable = 1'b1;
    endtask

    task automatic wait_done(output int cyc);
        cyc = 0;
        do begin
            @(posedge clk); cyc++;
            @(negedge clk);
            tx_wr = 1'b0;
        end while (done_o !== 1'b1 && cyc < 5000);
    endtask

    task automatic write_word(input logic [W-1:0] w);
        @(negedge clk); tx_word = w; tx_wr = 1'b1;
        @(negedge clk); tx_wr = 1'b0;
    endtask

    // R3, R4, R5: one word, full timing and data check
    task automatic t_word(input logic [7:0] n, input logic pol, input logic pha,
                          input logic [W-1:0] mw, input logic [W-1:0] sw);
        int cyc;
        int exp_cyc = 2 * W * (n + 1) + 2;
        setup(n, pol, pha, 1'b0);
        slave_arm(sw);
        @(negedge clk); tx_word = mw; tx_wr = 1'b1;
        wait_done(cyc);
        chk(cyc == exp_cyc, "R3 word duration", cyc, exp_cyc);
        chk(rx_word_o == sw, "R4 master received", rx_word_o, sw);
        chk(s_rx == mw, "R4 slave received", s_rx, mw);
        @(negedge clk);
        chk(done_o == 1'b0, "R5 done one cycle", done_o, 0);
        chk(rx_word_o == sw, "R5 rx held", rx_word_o, sw);
        chk(sck_o == pol, "R4 sck idle", sck_o, pol);
    endtask

    task automatic t_reset();
        chk(sck_o == 1'b0 && mosi_o == 1'b0, "R11 reset lines", {sck_o, mosi_o}, 0);
        chk(tx_full_o == 1'b0 && done_o == 1'b0 && err_o == 1'b0, "R11 reset flags",
            {tx_full_o, done_o, err_o}, 0);
        chk(rx_word_o == '0, "R11 reset rx", rx_word_o, 0);
    endtask

    // R6: second write while full is dropped
    task automatic t_tx_reg();
        int cyc;
        @(negedge clk); cfg_enable = 1'b0;
        cfg_div = 8'd1; cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_hs_en = 1'b0;
        tb_cpol = 1'b0; tb_cpha = 1'b0;
        slave_arm(8'h0F);
        write_word(8'hA5);
        write_word(8'h5A);
        chk(tx_full_o == 1'b1, "R6 full after write", tx_full_o, 1);
        @(negedge clk); cfg_enable = 1'b1;
        wait_done(cyc);
        chk(s_rx == 8'hA5, "R6 first word kept", s_rx, 8'hA5);
        chk(tx_full_o == 1'b0, "R6 full cleared", tx_full_o, 0);
    endtask

    // R1: mode gating
    task automatic t_gate();
        int cyc, tog0, d0;
        setup(8'd0, 1'b0, 1'b1, 1'b0);
        @(negedge clk); cfg_i2c_sel = 1'b1;
        slave_arm(8'h96);
        write_word(8'h3E);
        tog0 = sck_tog; d0 = done_cnt;
        repeat (40) @(negedge clk);
        chk(tx_full_o == 1'b1 && sck_tog == tog0 && done_cnt == d0, "R1 i2c select blocks",
            sck_tog - tog0, 0);
        cfg_i2c_sel = 1'b0; cfg_master = 1'b0;
        repeat (40) @(negedge clk);
        chk(tx_full_o == 1'b1 && sck_tog == tog0, "R1 slave mode blocks", sck_tog - tog0, 0);
        cfg_master = 1'b1;
        wait_done(cyc);
        chk(rx_word_o == 8'h96 && s_rx == 8'h3E, "R1 runs once allowed", rx_word_o, 8'h96);
    endtask

    // R2: settings frozen while on
    task automatic t_cfg_lock();
        int cyc;
        setup(8'd1, 1'b0, 1'b0, 1'b0);
        @(negedge clk); cfg_div = 8'd6; cfg_cpol = 1'b1; cfg_hs_en = 1'b1;
        slave_arm(8'hC3);
        @(negedge clk); tx_word = 8'h81; tx_wr = 1'b1;
        wait_done(cyc);
        chk(cyc == 2 * W * 2 + 2, "R2 divider change ignored", cyc, 2 * W * 2 + 2);
        chk(sck_o == 1'b0, "R2 polarity change ignored", sck_o, 0);
        chk(rx_word_o == 8'hC3, "R2 data intact", rx_word_o, 8'hC3);
        @(negedge clk); cfg_cpol = 1'b0; cfg_hs_en = 1'b0;
    endtask

    // R7: handshake pacing
    task automatic t_handshake();
        int cyc, tog0;
        setup(8'd2, 1'b1, 1'b1, 1'b1);
        hreq_n_i = 1'b1;
        slave_arm(8'h6D);
        write_word(8'hB2);
        tog0 = sck_tog;
        repeat (30) @(negedge clk);
        chk(tx_full_o == 1'b1 && sck_tog == tog0, "R7 held without request", tx_full_o, 1);
        hreq_n_i = 1'b0;
        wait_done(cyc);
        chk(rx_word_o == 8'h6D && s_rx == 8'hB2, "R7 runs on request", rx_word_o, 8'h6D);
        @(negedge clk); hreq_n_i = 1'b1;
    endtask

    // R8, R9, R10: select fault
    task automatic t_fault();
        int cyc, d0, tog0;
        setup(8'd3, 1'b0, 1'b0, 1'b0);
        slave_arm(8'h11);
        write_word(8'h3C);
        repeat (12) @(negedge clk);
        d0 = done_cnt;
        ss_n_i = 1'b0;
        @(negedge clk); @(negedge clk);
        chk(err_o == 1'b0, "R8 not before third edge", err_o, 0);
        @(negedge clk);
        chk(err_o == 1'b1, "R8 flag on third edge", err_o, 1);
        chk(sck_o == 1'b0, "R10 sck parked", sck_o, 0);
        tog0 = sck_tog;
        repeat (80) @(negedge clk);
        chk(done_cnt == d0 && sck_tog == tog0, "R10 word aborted", done_cnt - d0, 0);
        ss_n_i = 1'b1;
        repeat (5) @(negedge clk);
        chk(err_o == 1'b1, "R9 sticky", err_o, 1);
        write_word(8'h55);
        repeat (30) @(negedge clk);
        chk(tx_full_o == 1'b1 && done_cnt == d0, "R10 no start while error", tx_full_o, 1);
        slave_arm(8'hE7);
        err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
        chk(err_o == 1'b0, "R9 cleared", err_o, 0);
        wait_done(cyc);
        chk(rx_word_o == 8'hE7 && s_rx == 8'h55, "R10 resumes after clear", rx_word_o, 8'hE7);
        // fault wins over clear
        @(negedge clk); ss_n_i = 1'b0; err_clr = 1'b1;
        repeat (5) @(negedge clk);
        chk(err_o == 1'b1, "R9 fault beats clear", err_o, 1);
        ss_n_i = 1'b1;
        repeat (4) @(negedge clk);
        err_clr = 1'b0;
        chk(err_o == 1'b0, "R9 clear after fault gone", err_o, 0);
    endtask

    // R8: no fault while off
    task automatic t_fault_off();
        @(negedge clk); cfg_enable = 1'b0;
        ss_n_i = 1'b0;
        repeat (6) @(negedge clk);
        chk(err_o == 1'b0, "R8 ignored while off", err_o, 0);
        ss_n_i = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_word(8'd0, 1'b0, 1'b0, 8'hA3, 8'h5C);
        t_word(8'd1, 1'b0, 1'b1, 8'h81, 8'h7E);
        t_word(8'd2, 1'b1, 1'b0, 8'h4B, 8'hD2);
        t_word(8'd3, 1'b1, 1'b1, 8'hF0, 8'h0D);
        t_tx_reg();
        t_gate();
        t_cfg_lock();
        t_handshake();
        t_fault();
        t_fault_off();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule